// File: doc/BRIEF.md
# Parallel Input Word Packer

This block takes samples from a 20-pin parallel data bus. A capture happens on a chosen transition of an external port clock. The block assembles the samples into 32-bit words and offers each finished word to a downstream FIFO. The FIFO side uses a valid/ready handshake.

The port clock and data are oversampled in the system clock domain. They pass through a two-flop synchronizer, and then an edge detector raises a one-cycle capture event. The system clock must run at least four times faster than the port clock.

A narrow sample is always taken from the upper pins of the bus. The block offers four packing modes: four 8-bit samples, three samples of 11/11/10 bits, two 16-bit samples, or one 20-bit sample padded with twelve zero bits. Samples fill the word starting at the most significant end.

A single control register holds the following fields:
- an enable
- a capture-edge select
- the packing mode
- a write-only discard strobe
- a sticky overflow flag, which software clears by writing 1

The packing controller is a three-state machine:
- `ST_OFF` is the disabled state.
- `ST_FILL` collects samples.
- `ST_HOLD` presents a finished word until the FIFO accepts it.

The transitions are:
- `OFF→FILL` when the block is enabled.
- `FILL→HOLD` when the last sample of a word is captured.
- `HOLD→FILL` when the FIFO accepts the word.
- `HOLD→HOLD` when a word is accepted and, in the same cycle, a capture completes the next word.
- Any state goes to `OFF` when the enable reads 0.
- `FILL` or `HOLD` goes to `FILL` on a clear. A clear comes from the strobe, a mode change or a disabling write.

Top module: `par_pack_top`

## Requirements
- R1: After reset the register reads 0. The readback layout is bit 31 enable, bit 29 edge select, bits 28..27 packing mode and bit 0 overflow. All other bits read 0, including bit 30.
- R2: A sample is captured on a synchronized rising transition of the port clock when bit 29 is 0. It is captured on a falling transition when bit 29 is 1.
- R3: Mode 00 packs four samples taken from pins 19..12. The first sample lands in word bits 31..24 and the last in bits 7..0.
- R4: Mode 01 packs three samples. The first sample's pins 19..9 land in bits 31..21, the second sample's pins 19..9 in bits 20..10, and the third sample's pins 19..10 in bits 9..0.
- R5: Mode 10 packs two samples taken from pins 19..4. The first lands in bits 31..16 and the second in bits 15..0.
- R6: Mode 11 places pins 19..0 of one sample in bits 31..12, and bits 11..0 of the word are 0.
- R7: A finished word is offered with wr_valid. It is held stable until wr_ready is high in the same cycle.
- R8: While enable is 0, pin activity produces no words. Disabling drops both the partial word and any word waiting to be accepted.
- R9: Writing 1 to bit 30 discards the partial word and any waiting word, and bit 30 reads back as 0.
- R10: Writing a different packing mode discards the partial word and any waiting word. Packing restarts at the first slot.
- R11: A capture that arrives while a word waits with wr_ready low is dropped and sets the overflow bit. The overflow bit stays set until a write with bit 0 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback |
| pin_clk | input | 1 | External port clock |
| pin_data | input | 20 | External parallel data |
| wr_valid | output | 1 | Packed word available |
| wr_data | output | 32 | Packed word |
| wr_ready | input | 1 | FIFO can accept a word |

## Verification
The following properties are checked on every cycle:
- A waiting word stays stable while the FIFO stalls.
- No word is offered while the block is disabled.
- The discard strobe, a mode change and a disabling write each remove any offered word in the following cycle.
- The overflow flag only rises after a cycle in which a word was waiting and stalled.
- A mode-11 word always has zero low bits.

Only the bench scenarios can show that sample bits land in the right slots for every mode under both capture edges. The same holds for partial words actually being discarded so that packing restarts at slot 0, and for the dropped capture never reaching the FIFO.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int PP_PIN_W  = 20;
    localparam int PP_WORD_W = 32;

    typedef enum logic [1:0] {
        PM_BYTE  = 2'b00,
        PM_MIXED = 2'b01,
        PM_HALF  = 2'b10,
        PM_FULL  = 2'b11
    } pp_mode_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_FILL = 2'b01,
        ST_HOLD = 2'b10
    } pp_state_e;

    // index of the final slot of a word for each packing mode
    function automatic logic [1:0] pp_last_slot(input pp_mode_e m);
        unique case (m)
            PM_BYTE:  return 2'd3;
            PM_MIXED: return 2'd2;
            PM_HALF:  return 2'd1;
            PM_FULL:  return 2'd0;
        endcase
    endfunction

    // position a sample's MSB-aligned bits into its slot of the word
    function automatic logic [PP_WORD_W-1:0] pp_place(input pp_mode_e m,
                                                      input logic [1:0] slot,
                                                      input logic [PP_PIN_W-1:0] d);
        logic [PP_WORD_W-1:0] r;
        r = '0;
        unique case (m)
            PM_BYTE:  r = {d[19:12], 24'b0} >> (5'(slot) * 5'd8);
            PM_MIXED: begin
                unique case (slot)
                    2'd0:    r = {d[19:9], 21'b0};
                    2'd1:    r = {11'b0, d[19:9], 10'b0};
                    default: r = {22'b0, d[19:10]};
                endcase
            end
            PM_HALF:  r = {d[19:4], 16'b0} >> (5'(slot) * 5'd16);
            PM_FULL:  r = {d, 12'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pp_ctl_regs.sv
module pp_ctl_regs
    import pp_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             ovf_set,
    output logic [REG_W-1:0] reg_rdata,
    output logic             en,
    output logic             edge_fall,
    output pp_mode_e         mode,
    output logic             clr
);
    localparam int B_EN   = REG_W - 1;
    localparam int B_STB  = REG_W - 2;
    localparam int B_EDGE = REG_W - 3;
    localparam int B_MODE = REG_W - 4;

    logic     en_q, edge_q, ovf_q;
    pp_mode_e mode_q;
    pp_mode_e mode_w;
    logic     unused_wbits;

    assign mode_w       = pp_mode_e'(reg_wdata[B_MODE -: 2]);
    assign unused_wbits = ^reg_wdata[B_MODE-2:1];

    // discard pulse: strobe bit, mode change, or a write that disables
    assign clr = reg_wr && (reg_wdata[B_STB] || (mode_w != mode_q) || !reg_wdata[B_EN]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            edge_q <= 1'b0;
            mode_q <= PM_BYTE;
        end else if (reg_wr) begin
            en_q   <= reg_wdata[B_EN];
            edge_q <= reg_wdata[B_EDGE];
            mode_q <= mode_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ovf_q <= 1'b0;
        else if (ovf_set)                ovf_q <= 1'b1;
        else if (reg_wr && reg_wdata[0]) ovf_q <= 1'b0;
    end

    always_comb begin
        reg_rdata             = '0;
        reg_rdata[B_EN]       = en_q;
        reg_rdata[B_EDGE]     = edge_q;
        reg_rdata[B_MODE -: 2] = mode_q;
        reg_rdata[0]          = ovf_q;
    end

    assign en        = en_q;
    assign edge_fall = edge_q;
    assign mode      = mode_q;
endmodule

// File: rtl/pp_port_sync.sv
module pp_port_sync #(
    parameter int W      = 20,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_clk,
    input  logic [W-1:0] pin_data,
    input  logic         edge_fall,
    output logic         cap,
    output logic [W-1:0] cap_data
);
    logic [STAGES-1:0] ck_sr;
    logic [W-1:0]      dt_sr [STAGES];
    logic              ck_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ck_sr[0] <= 1'b0;
                        dt_sr[0] <= '0;
                    end else begin
                        ck_sr[0] <= pin_clk;
                        dt_sr[0] <= pin_data;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ck_sr[g] <= 1'b0;
                        dt_sr[g] <= '0;
                    end else begin
                        ck_sr[g] <= ck_sr[g-1];
                        dt_sr[g] <= dt_sr[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_prev <= 1'b0;
        else        ck_prev <= ck_sr[STAGES-1];
    end

    assign cap      = edge_fall ? (ck_prev && !ck_sr[STAGES-1])
                                : (!ck_prev && ck_sr[STAGES-1]);
    assign cap_data = dt_sr[STAGES-1];
endmodule

// File: rtl/pp_pack_fsm.sv
module pp_pack_fsm
    import pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  pp_mode_e             mode,
    input  logic                 clr,
    input  logic                 cap,
    input  logic [PP_PIN_W-1:0]  cap_data,
    input  logic                 wr_ready,
    output logic                 wr_valid,
    output logic [PP_WORD_W-1:0] wr_data,
    output logic                 ovf_set
);
    pp_state_e            state_q, state_d;
    logic [1:0]           slot_q;
    logic [PP_WORD_W-1:0] acc_q, word_q, acc_nx;
    logic                 live, accept, drop, last;

    assign live   = en && !clr && (state_q != ST_OFF);
    assign accept = live && cap && (state_q != ST_HOLD || wr_ready);
    assign drop   = live && cap && (state_q == ST_HOLD) && !wr_ready;
    assign last   = (slot_q == pp_last_slot(mode));
    assign acc_nx = acc_q | pp_place(mode, slot_q, cap_data);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en) state_d = ST_FILL;
            ST_FILL: if (accept && last) state_d = ST_HOLD;
            ST_HOLD: begin
                if (accept && last) state_d = ST_HOLD;
                else if (wr_ready)  state_d = ST_FILL;
            end
            default: state_d = ST_OFF;
        endcase
        if (!en)                        state_d = ST_OFF;
        else if (clr && state_q != ST_OFF) state_d = ST_FILL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // slot counter and word assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            acc_q  <= '0;
            word_q <= '0;
        end else if (!en || clr || state_q == ST_OFF) begin
            slot_q <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            if (last) begin
                slot_q <= '0;
                acc_q  <= '0;
                word_q <= acc_nx;
            end else begin
                slot_q <= slot_q + 2'd1;
                acc_q  <= acc_nx;
            end
        end
    end

    // outputs
    always_comb begin
        wr_valid = (state_q == ST_HOLD) && en;
        wr_data  = word_q;
        ovf_set  = drop;
    end
endmodule

// File: rtl/par_pack_top.sv
module par_pack_top
    import pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 pin_clk,
    input  logic [PP_PIN_W-1:0]  pin_data,
    output logic                 wr_valid,
    output logic [PP_WORD_W-1:0] wr_data,
    input  logic                 wr_ready
);
    logic                en, edge_fall, clr, cap, ovf_set;
    pp_mode_e            mode;
    logic [PP_PIN_W-1:0] cap_data;

    pp_ctl_regs #(.REG_W(32)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ovf_set   (ovf_set),
        .reg_rdata (reg_rdata),
        .en        (en),
        .edge_fall (edge_fall),
        .mode      (mode),
        .clr       (clr)
    );

    pp_port_sync #(.W(PP_PIN_W), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_clk   (pin_clk),
        .pin_data  (pin_data),
        .edge_fall (edge_fall),
        .cap       (cap),
        .cap_data  (cap_data)
    );

    pp_pack_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode     (mode),
        .clr      (clr),
        .cap      (cap),
        .cap_data (cap_data),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .ovf_set  (ovf_set)
    );
endmodule

// File: rtl/par_pack_check.sv
module par_pack_check (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        wr_valid,
    input logic [31:0] wr_data,
    input logic        wr_ready
);
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !reg_wr) |=> (wr_valid && $stable(wr_data)));

    a_r8_off_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !wr_valid);

    a_r9_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[30]) |=> !wr_valid);

    a_r10_mode_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[28:27] != reg_rdata[28:27]) |=> !wr_valid);

    a_r11_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[0]) |-> $past(wr_valid && !wr_ready));

    a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && reg_rdata[28:27] == 2'b11) |-> (wr_data[11:0] == 12'd0));

    a_r1_strobe_reads0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[30]) |=> !reg_rdata[30]);
endmodule

bind par_pack_top par_pack_check u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready)
);

// File: tb/par_pack_top_bench.sv
module par_pack_top_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pin_clk = 1'b0;
    logic [19:0] pin_data = '0;
    logic        wr_valid;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int          ng = 0;
    logic [31:0] got [0:63];
    logic [19:0] smp [0:3];
    logic [31:0] seed = 32'h1234_5678;
    logic        cur_edge = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    par_pack_top u_par_pack_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_clk(pin_clk), .pin_data(pin_data),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready && ng < 64) begin
            got[ng] = wr_data;
            ng = ng + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    function automatic logic [31:0] cfg(input logic e, input logic [1:0] m);
        return {1'b1, 1'b0, e, m, 27'd0};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // data set up on the inactive level, then the selected transition
    task automatic send(input logic [19:0] d);
        @(negedge clk);
        pin_clk = cur_edge;
        pin_data = d;
        idle(HALF);
        pin_clk = ~cur_edge;
        idle(HALF);
    endtask

    function automatic logic [19:0] next_smp();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[27:8];
    endfunction

    function automatic int spw(input logic [1:0] m);
        case (m)
            2'd0: return 4;
            2'd1: return 3;
            2'd2: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] expw(input logic [1:0] m);
        logic [31:0] r;
        case (m)
            2'd0: r = (32'(smp[0] >> 12) << 24) | (32'(smp[1] >> 12) << 16)
                    | (32'(smp[2] >> 12) << 8) | 32'(smp[3] >> 12);
            2'd1: r = (32'(smp[0] >> 9) << 21) | (32'(smp[1] >> 9) << 10)
                    | 32'(smp[2] >> 10);
            2'd2: r = (32'(smp[0] >> 4) << 16) | 32'(smp[1] >> 4);
            default: r = 32'(smp[0]) << 12;
        endcase
        return r;
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(reg_rdata == 32'd0, "R1 reset readback", reg_rdata, 32'd0);
        chk(wr_valid == 1'b0, "R1 reset valid", {31'd0, wr_valid}, 32'd0);

        // R2..R6 sweep: every mode under both capture edges
        for (int m = 0; m < 4; m++) begin
            for (int ed = 0; ed < 2; ed++) begin
                cur_edge = ed[0];
                wr_reg(cfg(ed[0], m[1:0]));
                wr_reg(cfg(ed[0], m[1:0]) | 32'h4000_0000);
                chk(reg_rdata == cfg(ed[0], m[1:0]), "R1 R2 field readback", reg_rdata,
                    cfg(ed[0], m[1:0]));
                ng = 0;
                for (int w = 0; w < 3; w++) begin
                    for (int i = 0; i < spw(m[1:0]); i++) begin
                        smp[i] = next_smp();
                        send(smp[i]);
                    end
                    idle(6);
                    e = expw(m[1:0]);
                    chk(ng == w + 1 && got[w] == e,
                        m == 0 ? "R3 R2 byte word" : m == 1 ? "R4 R2 mixed word" :
                        m == 2 ? "R5 R2 half word" : "R6 R2 full word", got[w], e);
                end
            end
        end

        // R8: disabled block ignores pins, then packing starts at slot 0
        cur_edge = 1'b0;
        wr_reg(32'd0);
        ng = 0;
        for (int i = 0; i < 3; i++) send(next_smp());
        idle(6);
        chk(ng == 0, "R8 disabled no words", ng, 0);
        wr_reg(cfg(1'b0, 2'd0));
        for (int i = 0; i < 4; i++) begin smp[i] = next_smp(); send(smp[i]); end
        idle(6);
        chk(ng == 1 && got[0] == expw(2'd0), "R8 restart after enable", got[0], expw(2'd0));

        // R9: strobe drops partial word
        ng = 0;
        send(next_smp());
        send(next_smp());
        wr_reg(cfg(1'b0, 2'd0) | 32'h4000_0000);
        chk(reg_rdata[30] == 1'b0, "R9 strobe reads 0", reg_rdata, cfg(1'b0, 2'd0));
        for (int i = 0; i < 4; i++) begin smp[i] = next_smp(); send(smp[i]); end
        idle(6);
        chk(ng == 1 && got[0] == expw(2'd0), "R9 partial discarded", got[0], expw(2'd0));

        // R10: mode change drops partial word
        ng = 0;
        send(next_smp());
        send(next_smp());
        wr_reg(cfg(1'b0, 2'd2));
        for (int i = 0; i < 2; i++) begin smp[i] = next_smp(); send(smp[i]); end
        idle(6);
        chk(ng == 1 && got[0] == expw(2'd2), "R10 mode change restart", got[0], expw(2'd2));

        // R7 R11: stall, drop, sticky overflow, W1C
        wr_reg(cfg(1'b0, 2'd3));
        ng = 0;
        wr_ready = 1'b0;
        smp[0] = next_smp();
        send(smp[0]);
        idle(4);
        chk(wr_valid && wr_data == expw(2'd3), "R7 word held", wr_data, expw(2'd3));
        send(next_smp());
        idle(6);
        chk(reg_rdata[0] == 1'b1, "R11 overflow set", reg_rdata, 32'd1);
        chk(wr_valid && wr_data == expw(2'd3), "R7 R11 held word unchanged", wr_data, expw(2'd3));
        @(negedge clk);
        wr_ready = 1'b1;
        idle(6);
        chk(ng == 1 && got[0] == expw(2'd3), "R11 dropped capture absent", ng, 1);
        chk(reg_rdata[0] == 1'b1, "R11 overflow sticky", reg_rdata, 32'd1);
        wr_reg(cfg(1'b0, 2'd3) | 32'd1);
        chk(reg_rdata[0] == 1'b0, "R11 overflow cleared", reg_rdata, 32'd0);

        // R8: disabling drops a waiting word
        wr_ready = 1'b0;
        smp[0] = next_smp();
        send(smp[0]);
        idle(4);
        wr_reg(32'd0);
        wr_ready = 1'b1;
        ng = 0;
        idle(4);
        wr_reg(cfg(1'b0, 2'd3));
        idle(6);
        chk(ng == 0 && !wr_valid, "R8 waiting word dropped", ng, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule